// File: doc/BRIEF.md
# Tagged Eight-Queue Port Hub with DMA Sequencer

This block connects a user-side control device to a word-level host port. It holds eight queues of 16 entries each. Four of them are outbound and carry words from the user toward the host. The other four are inbound and carry words from the host toward the user. Every entry is 68 bits wide: a 64-bit payload plus a 4-bit tag, and the tag always moves together with its payload.

The user reaches the queues through two identical ports, A and B. On each port a direction bit and a 2-bit selector choose one queue, and a valid/ready handshake moves a word in or out. If both ports select the same queue in the same cycle, port A wins.

A built-in sequencer decides when each queue needs host service, using its fill level and, for outbound queues, how long it has been idle. It visits the queues that need service in round-robin order and moves one word per granted host cycle. The host never stalls the user. It only grants the request the sequencer raises.

Top module: `tagfifo_dma_hub`

## Requirements
- R1: There are eight queues, numbered as channels. Channels 0 to 3 are outbound and are written by the user. Channels 4 to 7 are inbound and are read by the user. Each entry is 68 bits with the tag in bits [67:64]. Every word leaves a queue with the same payload and tag it entered with, and each queue keeps first-in first-out order.
- R2: On a port, `wr`=1 selects outbound queue `sel` and `wr`=0 selects inbound queue 4+`sel`. A word moves on a rising edge where `valid` and `ready` are both high. For a write, `ready` is low while the queue holds 16 entries. For a read, `ready` is low while the queue is empty. `rdata` shows the head entry of the selected inbound queue.
- R3: When both ports are valid and select the same queue, port B's `ready` is low and port A proceeds; B's word is neither dropped nor transferred twice. When the ports select different queues, both may proceed in the same cycle.
- R4: An outbound queue asks for host service while it holds at least AF_LVL entries (12 by default).
- R5: An outbound queue that holds data asks for host service once IDLE_CYC cycles (32 by default) have passed without a user write to it. Below AF_LVL, it does not ask before that.
- R6: An inbound queue asks for host service while it holds fewer than AE_LVL entries (4 by default). Each service adds one word, so the sequencer refills the queue up to AE_LVL.
- R7: Among the queues asking for service, the sequencer picks the first one at or after the channel following the last one served, wrapping from 7 to 0.
- R8: The host port presents `hst_req` together with `hst_chan`. For outbound channels it presents `hst_we`=1 and the head entry on `hst_wdata`. For inbound channels it presents `hst_we`=0 and captures `hst_rdata`. One word moves on each rising edge where `hst_req` and `hst_gnt` are both high.
- R9: After reset all queues are empty and the round-robin pointer is at channel 0. The first request is therefore for channel 4, and reads on every port are not ready.
- R10: When writes to a full queue or reads from an empty queue are held off, no word is lost or duplicated. A write held while the queue is full completes once the sequencer drains an entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_valid | input | 1 | Port A request |
| a_wr | input | 1 | Port A direction: 1 writes an outbound queue, 0 reads an inbound queue |
| a_sel | input | 2 | Port A queue selector |
| a_wdata | input | 68 | Port A write word, tag in [67:64] |
| a_ready | output | 1 | Port A may transfer |
| a_rdata | output | 68 | Head of the inbound queue selected on port A |
| b_valid | input | 1 | Port B request |
| b_wr | input | 1 | Port B direction |
| b_sel | input | 2 | Port B queue selector |
| b_wdata | input | 68 | Port B write word |
| b_ready | output | 1 | Port B may transfer |
| b_rdata | output | 68 | Head of the inbound queue selected on port B |
| hst_req | output | 1 | Sequencer requests a host word transfer |
| hst_we | output | 1 | 1: word goes to host; 0: word comes from host |
| hst_chan | output | 3 | Channel being serviced |
| hst_wdata | output | 68 | Word sent to the host |
| hst_gnt | input | 1 | Host accepts the current request |
| hst_rdata | input | 68 | Word from the host, sampled on a granted inbound cycle |

## Verification
The properties assume that the host supplies valid `hst_rdata` in every cycle it grants an inbound request. They also assume that the user inputs and `hst_gnt` are stable across each rising edge. Given those, they require that:
- a pending inbound request cannot vanish without a grant;
- a serviced outbound queue is never empty;
- a serviced inbound queue is below its refill level;
- every fill count moves by at most one per cycle and never exceeds the depth.

The bench respects these assumptions. It changes every input, including the host grant and the host data model, only at falling edges or one time unit after a rising edge. Its host model derives each returned word from a per-channel counter that advances only on granted cycles.

// File: rtl/tagfifo_dma_hub.sv
module tagfifo_dma_hub #(
  parameter int DW       = 64,
  parameter int TW       = 4,
  parameter int DEPTH    = 16,
  parameter int AF_LVL   = 12,
  parameter int AE_LVL   = 4,
  parameter int IDLE_CYC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_valid,
  input  logic             a_wr,
  input  logic [1:0]       a_sel,
  input  logic [DW+TW-1:0] a_wdata,
  output logic             a_ready,
  output logic [DW+TW-1:0] a_rdata,
  input  logic             b_valid,
  input  logic             b_wr,
  input  logic [1:0]       b_sel,
  input  logic [DW+TW-1:0] b_wdata,
  output logic             b_ready,
  output logic [DW+TW-1:0] b_rdata,
  output logic             hst_req,
  output logic             hst_we,
  output logic [2:0]       hst_chan,
  output logic [DW+TW-1:0] hst_wdata,
  input  logic             hst_gnt,
  input  logic [DW+TW-1:0] hst_rdata
);
  localparam int EW = DW + TW;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(IDLE_CYC + 1);

  logic [7:0][CW-1:0] cnt;
  logic [7:0][EW-1:0] head;
  logic [7:0] full, empty, elig, usr, hst;
  logic [2:0] a_f, b_f, pick, rr;
  logic       pick_ok, a_fire, b_fire, h_fire;

  assign a_f     = {~a_wr, a_sel};
  assign b_f     = {~b_wr, b_sel};
  assign a_ready = a_wr ? ~full[a_f] : ~empty[a_f];
  assign b_ready = (b_wr ? ~full[b_f] : ~empty[b_f]) & ~(a_valid & (a_f == b_f));
  assign a_fire  = a_valid & a_ready;
  assign b_fire  = b_valid & b_ready;
  assign a_rdata = head[{1'b1, a_sel}];
  assign b_rdata = head[{1'b1, b_sel}];

  assign hst_req   = pick_ok;
  assign hst_chan  = pick;
  assign hst_we    = ~pick[2];
  assign hst_wdata = head[pick];
  assign h_fire    = pick_ok & hst_gnt;

  always_comb begin
    pick    = '0;
    pick_ok = 1'b0;
    for (int k = 7; k >= 0; k--) begin
      if (elig[rr + 3'(k)]) begin
        pick    = rr + 3'(k);
        pick_ok = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      rr <= '0;
    else if (h_fire) rr <= pick + 3'd1;

  for (genvar g = 0; g < 8; g++) begin : g_q
    logic [EW-1:0] ram [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] n;
    logic          push, pop;
    logic [EW-1:0] din;

    assign usr[g] = (a_fire & (a_f == 3'(g))) | (b_fire & (b_f == 3'(g)));
    assign hst[g] = h_fire & (pick == 3'(g));

    if (g < 4) begin : g_out
      logic [IW-1:0] idle;
      assign push    = usr[g];
      assign pop     = hst[g];
      assign din     = (a_fire & (a_f == 3'(g))) ? a_wdata : b_wdata;
      assign elig[g] = (n >= CW'(AF_LVL)) | ((n != '0) & (idle == IW'(IDLE_CYC)));
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                      idle <= '0;
        else if (push)                   idle <= '0;
        else if (idle != IW'(IDLE_CYC))  idle <= idle + 1'b1;
    end else begin : g_in
      assign push    = hst[g];
      assign pop     = usr[g];
      assign din     = hst_rdata;
      assign elig[g] = n < CW'(AE_LVL);
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        wp <= '0;
        rp <= '0;
        n  <= '0;
      end else begin
        if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
        if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
        n <= n + CW'(push) - CW'(pop);
      end

    always_ff @(posedge clk)
      if (push) ram[wp] <= din;

    assign head[g]  = ram[rp];
    assign cnt[g]   = n;
    assign full[g]  = (n == CW'(DEPTH));
    assign empty[g] = (n == '0);
  end
endmodule

// File: rtl/tagfifo_dma_hub_chk.sv
module tagfifo_dma_hub_chk #(
  parameter int DEPTH  = 16,
  parameter int AE_LVL = 4,
  parameter int CW     = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               a_valid,
  input logic               a_wr,
  input logic [1:0]         a_sel,
  input logic               b_valid,
  input logic               b_wr,
  input logic [1:0]         b_sel,
  input logic               b_ready,
  input logic               hst_req,
  input logic               hst_we,
  input logic [2:0]         hst_chan,
  input logic               hst_gnt,
  input logic [7:0][CW-1:0] cnt
);
  p_b_yields_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && b_valid && a_wr == b_wr && a_sel == b_sel) |-> !b_ready);

  p_we_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hst_req |-> (hst_we == !hst_chan[2]));

  p_in_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_req && !hst_gnt && hst_chan[2]) |=> hst_req);

  p_out_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_req && !hst_chan[2]) |-> (cnt[hst_chan] != '0));

  p_in_below_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_req && hst_chan[2]) |-> (cnt[hst_chan] < CW'(AE_LVL)));

  for (genvar i = 0; i < 8; i++) begin : g_c
    p_cnt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[i] <= CW'(DEPTH)) &&
      (cnt[i] == $past(cnt[i]) || cnt[i] == $past(cnt[i]) + CW'(1) ||
       cnt[i] + CW'(1) == $past(cnt[i])));
  end
endmodule

bind tagfifo_dma_hub tagfifo_dma_hub_chk #(.DEPTH(DEPTH), .AE_LVL(AE_LVL), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_valid(a_valid), .a_wr(a_wr), .a_sel(a_sel),
  .b_valid(b_valid), .b_wr(b_wr), .b_sel(b_sel), .b_ready(b_ready),
  .hst_req(hst_req), .hst_we(hst_we), .hst_chan(hst_chan), .hst_gnt(hst_gnt),
  .cnt(cnt)
);

// File: tb/tagfifo_dma_hub_tb.sv
`timescale 1ns/1ps
module tagfifo_dma_hub_tb;
  localparam int IDLE = 32;

  logic        clk = 0, rst_n = 0;
  logic        a_valid = 0, a_wr = 0, b_valid = 0, b_wr = 0, hst_gnt = 0;
  logic [1:0]  a_sel = 0, b_sel = 0;
  logic [67:0] a_wdata = 0, b_wdata = 0, a_rdata, b_rdata, hst_wdata, hst_rdata;
  logic        a_ready, b_ready, hst_req, hst_we;
  logic [2:0]  hst_chan;

  int n_chk = 0, n_fail = 0;
  int src_n [4];
  logic [70:0] hlog [$];
  logic [67:0] expq [$];
  logic [67:0] q;

  always #10 clk = ~clk;

  tagfifo_dma_hub #(.DEPTH(16), .AF_LVL(12), .AE_LVL(4), .IDLE_CYC(IDLE)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_wr(a_wr), .a_sel(a_sel), .a_wdata(a_wdata),
    .a_ready(a_ready), .a_rdata(a_rdata),
    .b_valid(b_valid), .b_wr(b_wr), .b_sel(b_sel), .b_wdata(b_wdata),
    .b_ready(b_ready), .b_rdata(b_rdata),
    .hst_req(hst_req), .hst_we(hst_we), .hst_chan(hst_chan), .hst_wdata(hst_wdata),
    .hst_gnt(hst_gnt), .hst_rdata(hst_rdata));

  function automatic logic [67:0] src_word(int ch, int n);
    return {4'(ch * 5 + n), 32'hC0DE0000 | 32'(ch), 32'(n)};
  endfunction

  function automatic logic [67:0] uw(int k, int ch);
    return {4'(k * 7 + ch), 32'hFACE0000 | 32'(ch), 32'(k)};
  endfunction

  assign hst_rdata = src_word(int'(hst_chan), src_n[hst_chan[1:0]]);

  always @(posedge clk)
    if (rst_n && hst_req && hst_gnt) begin
      hlog.push_back({hst_chan, hst_we ? hst_wdata : hst_rdata});
      if (!hst_we) src_n[hst_chan[1:0]] <= src_n[hst_chan[1:0]] + 1;
    end

  task automatic chk(string tag, logic [71:0] act, logic [71:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_log(string tag, int ch);
    int k = 0;
    foreach (hlog[i]) begin
      if (int'(hlog[i][70:68]) == ch) begin
        if (k < expq.size()) chk(tag, 72'(hlog[i][67:0]), 72'(expq[k]));
        k++;
      end
    end
    chk(tag, 72'(k), 72'(expq.size()));
  endtask

  task automatic drv(bit pb, bit v, bit wr, logic [1:0] sel, logic [67:0] d);
    if (pb) begin b_valid = v; b_wr = wr; b_sel = sel; b_wdata = d; end
    else    begin a_valid = v; a_wr = wr; a_sel = sel; a_wdata = d; end
  endtask

  function automatic bit rdy(bit pb);
    return pb ? b_ready : a_ready;
  endfunction

  task automatic xfer(bit pb, bit wr, logic [1:0] sel, logic [67:0] d, output logic [67:0] r);
    @(negedge clk);
    drv(pb, 1, wr, sel, d);
    #1;
    for (int w = 0; w < 500 && !rdy(pb); w++) begin @(negedge clk); #1; end
    r = pb ? b_rdata : a_rdata;
    @(posedge clk); #1;
    drv(pb, 0, wr, sel, d);
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    chk("R9 first request", 72'(hst_req), 72'(1));
    chk("R7 first channel", 72'(hst_chan), 72'(4));
    chk("R8 inbound direction", 72'(hst_we), 72'(0));
    a_wr = 1; a_sel = 0; #1;
    chk("R2 write ready on empty outbound", 72'(a_ready), 72'(1));
    a_wr = 0; #1;
    chk("R9 read not ready after reset", 72'(a_ready), 72'(0));
  endtask

  task automatic t_fill;
    @(negedge clk); hst_gnt = 1;
    repeat (20) @(negedge clk);
    hst_gnt = 0; #1;
    chk("R6 refill count", 72'(hlog.size()), 72'(16));
    chk("R6 request drops at level", 72'(hst_req), 72'(0));
    for (int i = 0; i < 8; i++)
      chk("R7 round robin order", 72'(hlog[i][70:68]), 72'(4 + i % 4));
    for (int ch = 4; ch < 8; ch++) begin
      expq.delete();
      for (int n = 0; n < 4; n++) expq.push_back(src_word(ch, n));
      check_log("R8 inbound words", ch);
    end
    hlog.delete();
  endtask

  task automatic t_read;
    @(negedge clk); hst_gnt = 1;
    for (int k = 0; k < 6; k++) begin
      xfer(0, 0, 2, '0, q);
      chk("R1 inbound order and tag", 72'(q), 72'(src_word(6, k)));
    end
    repeat (10) @(negedge clk);
    hst_gnt = 0;
    for (int k = 0; k < 4; k++) begin
      xfer(1, 0, 1, '0, q);
      chk("R2 read head", 72'(q), 72'(src_word(5, k)));
    end
    @(negedge clk);
    drv(1, 1, 0, 1, '0); #1;
    chk("R2 read blocked on empty", 72'(b_ready), 72'(0));
    chk("R6 empty inbound requests", 72'({hst_req, hst_chan}), 72'({1'b1, 3'd5}));
    repeat (2) begin
      @(negedge clk); #1;
      chk("R10 read stays blocked", 72'(b_ready), 72'(0));
    end
    hst_gnt = 1;
    @(negedge clk); #1;
    chk("R10 read resumes", 72'(b_ready), 72'(1));
    chk("R10 next word not skipped", 72'(b_rdata), 72'(src_word(5, 4)));
    @(posedge clk); #1;
    drv(1, 0, 0, 1, '0);
    repeat (10) @(negedge clk);
    hst_gnt = 0;
    hlog.delete();
  endtask

  task automatic t_thresh;
    hst_gnt = 0;
    for (int k = 0; k < 11; k++) xfer(0, 1, 1, uw(k, 1), q);
    chk("R4 below threshold no request", 72'(hst_req), 72'(0));
    xfer(0, 1, 1, uw(11, 1), q);
    chk("R4 threshold request", 72'({hst_req, hst_we, hst_chan}), 72'({1'b1, 1'b1, 3'd1}));
    chk("R8 head on host data", 72'(hst_wdata), 72'(uw(0, 1)));
    @(negedge clk); hst_gnt = 1;
    @(negedge clk); hst_gnt = 0; #1;
    chk("R4 request drops below threshold", 72'(hst_req), 72'(0));
    repeat (20) @(negedge clk);
    #1 chk("R5 no request before idle limit", 72'(hst_req), 72'(0));
    repeat (14) @(negedge clk);
    #1 chk("R5 idle flush request", 72'({hst_req, hst_chan}), 72'({1'b1, 3'd1}));
    hst_gnt = 1;
    repeat (20) @(negedge clk);
    hst_gnt = 0;
    expq.delete();
    for (int k = 0; k < 12; k++) expq.push_back(uw(k, 1));
    check_log("R1 outbound order and tag", 1);
    hlog.delete();
  endtask

  task automatic t_full;
    hst_gnt = 0;
    for (int k = 0; k < 16; k++) xfer(1, 1, 3, uw(k, 3), q);
    @(negedge clk);
    drv(1, 1, 1, 3, uw(16, 3)); #1;
    chk("R10 write blocked on full", 72'(b_ready), 72'(0));
    chk("R4 full queue requests", 72'({hst_req, hst_chan}), 72'({1'b1, 3'd3}));
    repeat (2) begin
      @(negedge clk); #1;
      chk("R10 write stays blocked", 72'(b_ready), 72'(0));
    end
    hst_gnt = 1;
    @(negedge clk); #1;
    chk("R10 write resumes after drain", 72'(b_ready), 72'(1));
    @(posedge clk); #1;
    drv(1, 0, 1, 3, '0);
    repeat (80) @(negedge clk);
    hst_gnt = 0;
    expq.delete();
    for (int k = 0; k < 17; k++) expq.push_back(uw(k, 3));
    check_log("R10 no loss or duplicate", 3);
    hlog.delete();
  endtask

  task automatic t_conflict;
    hst_gnt = 0;
    @(negedge clk);
    drv(0, 1, 1, 0, uw(0, 0));
    drv(1, 1, 1, 0, uw(1, 0)); #1;
    chk("R3 same queue A ready", 72'(a_ready), 72'(1));
    chk("R3 same queue B stalled", 72'(b_ready), 72'(0));
    @(posedge clk); #1;
    drv(0, 0, 1, 0, '0); #1;
    chk("R3 B proceeds after A", 72'(b_ready), 72'(1));
    @(posedge clk); #1;
    drv(1, 0, 1, 0, '0);
    @(negedge clk);
    drv(0, 1, 1, 2, uw(2, 2));
    drv(1, 1, 1, 0, uw(3, 0)); #1;
    chk("R3 different queues both ready", 72'({a_ready, b_ready}), 72'(2'b11));
    @(posedge clk); #1;
    drv(0, 0, 1, 2, '0);
    drv(1, 0, 1, 0, '0);
    @(negedge clk);
    drv(0, 1, 0, 0, '0);
    drv(1, 1, 0, 0, '0); #1;
    chk("R3 same inbound A ready", 72'(a_ready), 72'(1));
    chk("R3 same inbound B stalled", 72'(b_ready), 72'(0));
    drv(0, 0, 0, 0, '0);
    drv(1, 0, 0, 0, '0);
    xfer(0, 0, 0, '0, q);
    chk("R3 stalled read consumed nothing", 72'(q), 72'(src_word(4, 0)));
    hst_gnt = 1;
    repeat (80) @(negedge clk);
    hst_gnt = 0;
    expq.delete();
    expq.push_back(uw(0, 0)); expq.push_back(uw(1, 0)); expq.push_back(uw(3, 0));
    check_log("R3 both words kept in order", 0);
    expq.delete();
    expq.push_back(uw(2, 2));
    check_log("R3 parallel write delivered", 2);
    hlog.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) src_n[i] = 0;
    t_reset();
    t_fill();
    t_read();
    t_thresh();
    t_full();
    t_conflict();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule